// File: doc/BRIEF.md
# Per-Core Access Intensity Tracker

This block measures how hard each of four cores is driving main memory. For every core it counts read-issue and write-issue strobes over a fixed observation window and turns each count into an intensity figure in hundredths: 0 means idle and 100 means the core has reached the ceiling for that kind of access. Reads are scaled against a ceiling of 2048 per window and writes against a ceiling of 512, so a read-heavy and a write-heavy core can be compared on the same 0 to 100 scale.

The window is 65,536 clock cycles long by default and is timed by a free-running counter inside the block. When a window closes, the counters are not cleared. Each one restarts from half of the value it held at the end of the window. Short bursts therefore fade out over a few windows, while a steady load settles at a stable figure. The intensity outputs follow the counters directly, so a placement engine can read them at any time.

Top module: `access_tracker`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on the first cycle after it is released, every read and write intensity output is 0 and the window timer is at zero.
- R2: Each cycle with a core's read strobe high adds one to that core's read count. The read intensity is floor(count * 100 / 2048). For example, 1536 reads give 75.
- R3: Each cycle with a core's write strobe high adds one to that core's write count. The write intensity is floor(count * 100 / 512). For example, 384 writes give 75.
- R4: The read count (11 bits) stops at 2047 and the write count (9 bits) stops at 511. Neither wraps. A count held at its maximum reports intensity 100.
- R5: A window lasts 2^WIN_LOG2 cycles, counted from reset release. On the clock edge that closes the last cycle of a window, every counter is reloaded with floor(final / 2).
- R6: A strobe that arrives in the last cycle of a window is counted in the new window. It is added after the halved value is loaded, so a count of 10 followed by a boundary strobe becomes 6.
- R7: The cores are tracked independently, and strobes on one core never change another core's outputs. Core k's intensity sits in bits [7k+6:7k] of its flat output vector.
- R8: Every intensity output lies in the range 0 to 100 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| rd_ev_i | input | NUM_CORES | One read-issue strobe per core, one count per high cycle |
| wr_ev_i | input | NUM_CORES | One write-issue strobe per core, one count per high cycle |
| rd_level_o | output | NUM_CORES*7 | Per-core read intensity in hundredths (0 to 100) |
| wr_level_o | output | NUM_CORES*7 | Per-core write intensity in hundredths (0 to 100) |

## Verification
The properties assume that rst_n is deasserted in step with the clock, so the window timer starts from zero on a known edge. They also assume that each strobe input is a clean level sampled once per cycle, so that one high cycle means exactly one access. The stimulus drives both strobe vectors and the reset only on falling clock edges and holds every strobe for exactly one cycle. The windowed properties are exercised with a shorter window override, which lets the boundary reseed, boundary-coincident strobes and saturation all occur several times within the run.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
  localparam int LEVEL_W = 7;
  localparam logic [LEVEL_W-1:0] LEVEL_FULL = 7'd100;
  typedef logic [LEVEL_W-1:0] level_t;
endpackage

// File: rtl/tracker_window_timer.sv
module tracker_window_timer #(
  parameter int WIN_LOG2 = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [WIN_LOG2-1:0] tick_o,
  output logic                last_o
);
  localparam logic [WIN_LOG2-1:0] ONE = 1;

  logic [WIN_LOG2-1:0] tick_q, tick_d;

  always_comb begin
    tick_d = tick_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;
  assign last_o = &tick_q;
endmodule

// File: rtl/tracker_sat_counter.sv
module tracker_sat_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_i,
  input  logic         wrap_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] cnt_q, cnt_d, base;
  logic         en;

  // The halved seed is formed first, then the strobe of this cycle is added on top.
  always_comb begin
    base  = wrap_i ? (cnt_q >> 1) : cnt_q;
    cnt_d = (ev_i && !(&base)) ? base + ONE : base;
    en    = ev_i | wrap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tracker_level_scale.sv
module tracker_level_scale
  import tracker_pkg::*;
#(
  parameter int W = 11
) (
  input  logic [W-1:0] cnt_i,
  output level_t       level_o
);
  localparam int EW = W + LEVEL_W;
  localparam logic [EW-1:0] HUNDRED = 100;

  always_comb begin
    if (&cnt_i) level_o = LEVEL_FULL;
    else        level_o = LEVEL_W'(((EW'(cnt_i)) * HUNDRED) >> W);
  end
endmodule

// File: rtl/access_tracker.sv
module access_tracker
  import tracker_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WIN_LOG2  = 16,
  parameter int RD_W      = 11,
  parameter int WR_W      = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES-1:0]         rd_ev_i,
  input  logic [NUM_CORES-1:0]         wr_ev_i,
  output logic [NUM_CORES*LEVEL_W-1:0] rd_level_o,
  output logic [NUM_CORES*LEVEL_W-1:0] wr_level_o
);
  logic [WIN_LOG2-1:0]             timer_q;
  logic                            win_end;
  logic [NUM_CORES-1:0][RD_W-1:0]  rd_cnt;
  logic [NUM_CORES-1:0][WR_W-1:0]  wr_cnt;

  tracker_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (timer_q),
    .last_o (win_end)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    level_t rd_lvl, wr_lvl;

    tracker_sat_counter #(.W(RD_W)) u_rd_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (rd_ev_i[k]),
      .wrap_i (win_end),
      .cnt_o  (rd_cnt[k])
    );

    tracker_sat_counter #(.W(WR_W)) u_wr_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_i   (wr_ev_i[k]),
      .wrap_i (win_end),
      .cnt_o  (wr_cnt[k])
    );

    tracker_level_scale #(.W(RD_W)) u_rd_scale (
      .cnt_i   (rd_cnt[k]),
      .level_o (rd_lvl)
    );

    tracker_level_scale #(.W(WR_W)) u_wr_scale (
      .cnt_i   (wr_cnt[k]),
      .level_o (wr_lvl)
    );

    assign rd_level_o[k*LEVEL_W +: LEVEL_W] = rd_lvl;
    assign wr_level_o[k*LEVEL_W +: LEVEL_W] = wr_lvl;
  end
endmodule

// File: rtl/tracker_checker.sv
module tracker_checker #(
  parameter int NUM_CORES = 4,
  parameter int WIN_LOG2  = 16,
  parameter int RD_W      = 11,
  parameter int WR_W      = 9
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [WIN_LOG2-1:0]            timer_q,
  input logic                           win_end,
  input logic [NUM_CORES-1:0]           rd_ev_i,
  input logic [NUM_CORES-1:0]           wr_ev_i,
  input logic [NUM_CORES-1:0][RD_W-1:0] rd_cnt,
  input logic [NUM_CORES-1:0][WR_W-1:0] wr_cnt,
  input logic [NUM_CORES*7-1:0]         rd_level_o,
  input logic [NUM_CORES*7-1:0]         wr_level_o
);
  localparam logic [RD_W-1:0]     RD_MAX = '1;
  localparam logic [WR_W-1:0]     WR_MAX = '1;
  localparam logic [RD_W-1:0]     RD_ONE = 1;
  localparam logic [WR_W-1:0]     WR_ONE = 1;
  localparam logic [WIN_LOG2-1:0] T_ONE  = 1;

  // R5: the timer advances by one every cycle
  p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> timer_q == $past(timer_q) + T_ONE);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
    // R2: a read strobe inside a window adds exactly one below the ceiling
    p_read_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && rd_ev_i[k] && rd_cnt[k] != RD_MAX) |=> rd_cnt[k] == $past(rd_cnt[k]) + RD_ONE);
    // R2: no read strobe inside a window leaves the count unchanged
    p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && !rd_ev_i[k]) |=> $stable(rd_cnt[k]));
    // R3: a write strobe inside a window adds exactly one below the ceiling
    p_write_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && wr_ev_i[k] && wr_cnt[k] != WR_MAX) |=> wr_cnt[k] == $past(wr_cnt[k]) + WR_ONE);
    // R4: a count at its maximum stays there inside a window
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && rd_cnt[k] == RD_MAX) |=> rd_cnt[k] == RD_MAX);
    p_no_overflow_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && wr_cnt[k] == WR_MAX) |=> wr_cnt[k] == WR_MAX);
    // R4: a full count reports 100
    p_full_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cnt[k] == RD_MAX) |-> rd_level_o[k*7 +: 7] == 7'd100);
    // R5: a quiet boundary reloads half the final count
    p_seed_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !rd_ev_i[k]) |=> rd_cnt[k] == ($past(rd_cnt[k]) >> 1));
    // R6: a boundary strobe is added after halving
    p_seed_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && wr_ev_i[k]) |=> wr_cnt[k] == ($past(wr_cnt[k]) >> 1) + WR_ONE);
    // R8: outputs stay in range
    p_level_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_level_o[k*7 +: 7] <= 7'd100 && wr_level_o[k*7 +: 7] <= 7'd100);
  end
endmodule

bind access_tracker tracker_checker #(
  .NUM_CORES (NUM_CORES),
  .WIN_LOG2  (WIN_LOG2),
  .RD_W      (RD_W),
  .WR_W      (WR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .timer_q    (timer_q),
  .win_end    (win_end),
  .rd_ev_i    (rd_ev_i),
  .wr_ev_i    (wr_ev_i),
  .rd_cnt     (rd_cnt),
  .wr_cnt     (wr_cnt),
  .rd_level_o (rd_level_o),
  .wr_level_o (wr_level_o)
);

// File: tb/access_tracker_tb.sv
module access_tracker_tb;
  localparam int NC   = 4;
  localparam int WLOG = 12;
  localparam int WIN  = 1 << WLOG;
  localparam int RMAX = 2047;
  localparam int WMAX = 511;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] rd_ev = '0;
  logic [NC-1:0] wr_ev = '0;
  logic [NC*7-1:0] rd_level, wr_level;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int m_rd [NC];
  int m_wr [NC];

  always #2 clk = ~clk;

  access_tracker #(.NUM_CORES(NC), .WIN_LOG2(WLOG), .RD_W(11), .WR_W(9)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ev_i    (rd_ev),
    .wr_ev_i    (wr_ev),
    .rd_level_o (rd_level),
    .wr_level_o (wr_level)
  );

  function automatic int lvl(int c, int bits, int mx);
    if (c >= mx) return 100;
    return (c * 100) >> bits;
  endfunction

  function automatic int rd_lane(int k);
    return int'(rd_level[k*7 +: 7]);
  endfunction

  function automatic int wr_lane(int k);
    return int'(wr_level[k*7 +: 7]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NC; k++) begin
      check(req, $sformatf("core%0d read level", k), rd_lane(k), lvl(m_rd[k], 11, RMAX));
      check(req, $sformatf("core%0d write level", k), wr_lane(k), lvl(m_wr[k], 9, WMAX));
      check("R8", $sformatf("core%0d range", k), int'(rd_lane(k) <= 100 && wr_lane(k) <= 100), 1);
    end
  endtask

  // one clock with the given strobes; the bench model follows the requirements
  task automatic step(logic [NC-1:0] rm, logic [NC-1:0] wm);
    bit wrap;
    rd_ev = rm;
    wr_ev = wm;
    @(posedge clk);
    wrap = (ph == WIN - 1);
    for (int k = 0; k < NC; k++) begin
      if (wrap) begin
        m_rd[k] = m_rd[k] / 2;
        m_wr[k] = m_wr[k] / 2;
      end
      if (rm[k] && m_rd[k] < RMAX) m_rd[k]++;
      if (wm[k] && m_wr[k] < WMAX) m_wr[k]++;
    end
    ph = (ph + 1) % WIN;
    @(negedge clk);
    rd_ev = '0;
    wr_ev = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rd_ev = '0;
    wr_ev = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ph = 0;
    for (int k = 0; k < NC; k++) begin
      m_rd[k] = 0;
      m_wr[k] = 0;
    end
  endtask

  task automatic idle_to_last();
    while (ph != WIN - 1) step('0, '0);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 20; i++) step(4'b1111, 4'b1111);
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      check("R1", "read level during reset", rd_lane(k), 0);
      check("R1", "write level during reset", wr_lane(k), 0);
    end
    do_reset();
    check_all("R1");
  endtask

  task automatic t_read_scale();
    do_reset();
    for (int i = 0; i < 1536; i++) step(4'b0001, '0);
    check("R2", "1536 reads on core0", rd_lane(0), 75);
    check("R7", "core1 untouched by core0 reads", rd_lane(1), 0);
    check_all("R2");
  endtask

  task automatic t_write_scale();
    do_reset();
    for (int i = 0; i < 384; i++) step('0, 4'b0100);
    check("R3", "384 writes on core2", wr_lane(2), 75);
    check("R7", "core2 read level untouched by writes", rd_lane(2), 0);
    check_all("R3");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 2100; i++) step(4'b1111, 4'b1111);
    for (int k = 0; k < NC; k++) begin
      check("R4", "read level held at ceiling", rd_lane(k), 100);
      check("R4", "write level held at ceiling", wr_lane(k), 100);
    end
  endtask

  task automatic t_window();
    do_reset();
    for (int i = 0; i < 1000; i++) step(4'b1000, '0);
    idle_to_last();
    check("R5", "core3 read level before boundary", rd_lane(3), 48);
    step('0, '0);
    check("R5", "core3 read level after halving", rd_lane(3), 24);
    check_all("R5");
  endtask

  task automatic t_boundary_event();
    do_reset();
    for (int i = 0; i < 10; i++) step('0, 4'b0001);
    idle_to_last();
    check("R6", "core0 write level at 10", wr_lane(0), 1);
    step('0, 4'b0001);
    check("R6", "boundary write counted after halving", wr_lane(0), 1);
    for (int i = 0; i < 2; i++) step('0, '0);
    check("R6", "core0 write level stable after boundary", wr_lane(0), 1);
    check_all("R6");
  endtask

  task automatic t_mixed();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int i = 0; i < 9000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] & 4'b1011, lfsr[7:4] | {3'b000, lfsr[8]});
      if (i % 512 == 511) begin
        check_all("R7");
        check("R7", "core2 read stays idle", rd_lane(2), 0);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_read_scale();
    t_write_scale();
    t_saturate();
    t_window();
    t_boundary_event();
    t_mixed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule